// File: doc/BRIEF.md
# Per-Cluster Fetch Thread Selector

This block decides, on every clock, which hardware thread context owns the fetch access of each fetch lane. A lane is one cache/target-buffer cluster. The block tracks up to eight contexts. For each context, three inputs describe it: a valid bit, a cluster index and a flag that marks an outstanding cache miss.

The block runs in one of two modes, chosen at run time:

- **Split mode.** Every lane grants one thread per cycle, and only from among the threads assigned to that lane.
- **Unified mode.** Lane 0 alone grants one thread, chosen from all contexts, and the other lanes stay idle.

Inside a lane, arbitration is round-robin and resumes after the thread granted last.

Eligibility, cluster indices and the mode are registered before arbitration. The decision therefore works on information that is one cycle old, which keeps the choice out of the next-address loop.

Each grant comes with the address to fetch, and the block picks one of two sources for it:

- **Computed next PC.** Used when the lane switches to a different thread than the one it served in the previous cycle. The architecturally computed next PC of the new thread is used, because the cluster's next-block prediction belongs to another thread.
- **Next-block prediction.** Used when the same thread continues on the lane.

A change of mode, or a move of a thread between clusters, restarts the affected lanes. Their pointers go back to thread 0, and the next grant on those lanes uses the computed PC.

Top module: `fetch_thread_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every lane's grant-valid output is 0.
- R2: In split mode (`unified_i`=0), lane c grants only a thread whose cluster index, bits [t*CW +: CW] of `thr_cluster_i` for thread t, equalled c when eligibility was sampled.
- R3: In unified mode (`unified_i`=1), lane 0 may grant a thread of any cluster, and every lane above 0 shows grant-valid 0.
- R4: A thread whose valid bit was 0, or whose miss flag was 1, when eligibility was sampled is never granted.
- R5: A lane grants the first eligible thread after its last granted thread index, in ascending order and wrapping from the highest index to 0.
- R6: A lane with no eligible thread shows grant-valid 0.
- R7: Inputs are sampled at a clock edge into the eligibility stage, and the grant that uses them appears after the following edge, i.e. two edges after the inputs are applied.
- R8: `pc_calc_o[c]`=1 and `fetch_pc_o` lane c equals the granted thread's slice of `thr_pc_i` (bits [t*PC_W +: PC_W]) whenever lane c grants a thread other than its grant of the previous cycle, or was idle then. When the same thread is granted on consecutive cycles, `pc_calc_o[c]`=0 and the lane shows its slice of `pred_pc_i`.
- R9: A change of mode, or a change of any thread's cluster index, makes each affected lane restart its search at thread 0, and the lane's next grant uses the computed PC. In a cluster-index change, the affected lanes are the old and new clusters. In a mode change, all lanes are affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unified_i | input | 1 | 1 = one shared lane, 0 = one grant per cluster |
| thr_valid_i | input | NT | Context holds a live thread |
| thr_miss_i | input | NT | Context waits on an instruction-cache miss |
| thr_cluster_i | input | NT*CW | Cluster index per thread, CW = log2(NC) |
| thr_pc_i | input | NT*PC_W | Computed next PC per thread |
| pred_pc_i | input | NC*PC_W | Next-block prediction per lane |
| gnt_vld_o | output | NC | Lane has a grant this cycle |
| gnt_tid_o | output | NC*TW | Granted thread index per lane, TW = log2(NT) |
| fetch_pc_o | output | NC*PC_W | Fetch address per lane |
| pc_calc_o | output | NC | 1 = address taken from the computed PC |

## Verification
A grant is due two rising edges after the inputs behind it are driven: one edge loads the eligibility stage, and the next edge loads the lane grant. The fetch address and its source flag follow the registered grant in the same cycle. Every cycle, the bench drives inputs on the falling edge and runs an independent model of one arbitration edge from its own copy of the stale eligibility. It queues the expected lane results, and a monitor pops and compares them one time unit after the next rising edge. Stimulus sets are held for several cycles, so that rotation, miss masking, a one-cycle miss pulse, mode flips and cluster moves all show at the cycle the latency predicts.

// File: rtl/fts_pkg.sv
package fts_pkg;

   typedef enum logic {
      SRC_PRED = 1'b0,
      SRC_CALC = 1'b1
   } pc_src_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fts_elig_stage.sv
module fts_elig_stage #(
   parameter  int NT   = 8,
   parameter  int NC   = 2,
   localparam int CL_W = $clog2(NC)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        unified_i,
   input  logic [NT-1:0]               thr_valid_i,
   input  logic [NT-1:0]               thr_miss_i,
   input  logic [NT*CL_W-1:0]          thr_cluster_i,
   output logic [NC-1:0][NT-1:0]       cand_o,
   output logic [NC-1:0]               flush_o,
   output logic                        uni_o
);

   logic [NT-1:0]            elig_q;
   logic [NT-1:0][CL_W-1:0]  clus_q;
   logic [NT-1:0][CL_W-1:0]  clus_d;
   logic                     uni_q;
   logic [NC-1:0]            flush_q;
   logic [NC-1:0]            flush_d;

   assign clus_d = thr_cluster_i;

   // restart lanes touched by a mode flip or a cluster move
   always_comb begin
      for (int c = 0; c < NC; c++) begin
         flush_d[c] = (unified_i != uni_q);
         for (int t = 0; t < NT; t++) begin
            if ((clus_d[t] != clus_q[t]) &&
                ((clus_q[t] == CL_W'(c)) || (clus_d[t] == CL_W'(c))))
               flush_d[c] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elig_q  <= '0;
         clus_q  <= '0;
         uni_q   <= 1'b0;
         flush_q <= '0;
      end else begin
         elig_q  <= thr_valid_i & ~thr_miss_i;
         clus_q  <= clus_d;
         uni_q   <= unified_i;
         flush_q <= flush_d;
      end
   end

   // candidate mask per lane from the one-cycle-old snapshot
   always_comb begin
      for (int c = 0; c < NC; c++) begin
         for (int t = 0; t < NT; t++) begin
            cand_o[c][t] = elig_q[t] &
                           (uni_q ? (c == 0) : (clus_q[t] == CL_W'(c)));
         end
      end
   end

   assign flush_o = flush_q;
   assign uni_o   = uni_q;

endmodule

// File: rtl/fts_rr_arb.sv
module fts_rr_arb #(
   parameter  int NT    = 8,
   localparam int TID_W = $clog2(NT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NT-1:0]    cand_i,
   input  logic             flush_i,
   output logic             gnt_vld_o,
   output logic [TID_W-1:0] gnt_tid_o,
   output logic             calc_pc_o
);

   localparam logic [TID_W-1:0] LAST = TID_W'(NT - 1);

   logic [TID_W-1:0] ptr_q;
   logic [TID_W-1:0] ptr_eff;
   logic [TID_W-1:0] idx;
   logic [TID_W-1:0] pick;
   logic             found;
   logic             gv_q;
   logic [TID_W-1:0] gid_q;
   logic             src_q;

   always_comb begin
      ptr_eff = flush_i ? LAST : ptr_q;
      found   = 1'b0;
      pick    = '0;
      idx     = ptr_eff;
      for (int i = 1; i <= NT; i++) begin
         idx = ptr_eff + TID_W'(i);
         if (!found && cand_i[idx]) begin
            found = 1'b1;
            pick  = idx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gv_q  <= 1'b0;
         gid_q <= '0;
         src_q <= 1'b0;
         ptr_q <= LAST;
      end else begin
         gv_q  <= found;
         src_q <= found & (flush_i | ~gv_q | (gid_q != pick));
         if (found) begin
            gid_q <= pick;
            ptr_q <= pick;
         end else if (flush_i) begin
            ptr_q <= LAST;
         end
      end
   end

   assign gnt_vld_o = gv_q;
   assign gnt_tid_o = gid_q;
   assign calc_pc_o = src_q;

   // R2 R4
   elig_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o |-> ((($past(cand_i) >> gnt_tid_o) & NT'(1)) != '0));

   // R6
   idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_i == '0) |=> !gnt_vld_o);

   // R8
   repeat_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld_o && $past(gnt_vld_o) && (gnt_tid_o == $past(gnt_tid_o)) &&
       !$past(flush_i)) |-> !calc_pc_o);

   // R8
   fresh_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_vld_o && !$past(gnt_vld_o)) |-> calc_pc_o);

   // R9
   flush_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!gnt_vld_o || calc_pc_o));

endmodule

// File: rtl/fts_pc_mux.sv
module fts_pc_mux #(
   parameter  int NT    = 8,
   parameter  int PC_W  = 32,
   localparam int TID_W = $clog2(NT)
) (
   input  logic [TID_W-1:0] gnt_tid_i,
   input  logic             calc_sel_i,
   input  logic [NT*PC_W-1:0] thr_pc_i,
   input  logic [PC_W-1:0]  pred_pc_i,
   output logic [PC_W-1:0]  fetch_pc_o
);

   import fts_pkg::*;

   logic [NT-1:0][PC_W-1:0] pcs;
   pc_src_e                 src;

   assign pcs = thr_pc_i;
   assign src = pc_src_e'(calc_sel_i);

   always_comb begin
      unique case (src)
         SRC_CALC: fetch_pc_o = pcs[gnt_tid_i];
         default:  fetch_pc_o = pred_pc_i;
      endcase
   end

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
   parameter  int NT    = 8,
   parameter  int NC    = 2,
   parameter  int PC_W  = 32,
   localparam int TID_W = $clog2(NT),
   localparam int CL_W  = $clog2(NC)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  unified_i,
   input  logic [NT-1:0]         thr_valid_i,
   input  logic [NT-1:0]         thr_miss_i,
   input  logic [NT*CL_W-1:0]    thr_cluster_i,
   input  logic [NT*PC_W-1:0]    thr_pc_i,
   input  logic [NC*PC_W-1:0]    pred_pc_i,
   output logic [NC-1:0]         gnt_vld_o,
   output logic [NC*TID_W-1:0]   gnt_tid_o,
   output logic [NC*PC_W-1:0]    fetch_pc_o,
   output logic [NC-1:0]         pc_calc_o
);

   if (!fts_pkg::is_pow2(NT) || NT < 2) begin : g_bad_nt
      $error("fetch_thread_sel: NT must be a power of two >= 2");
   end
   if (!fts_pkg::is_pow2(NC) || NC < 2 || NC > NT) begin : g_bad_nc
      $error("fetch_thread_sel: NC must be a power of two in 2..NT");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("fetch_thread_sel: PC_W too small");
   end

   logic [NC-1:0][NT-1:0] cand;
   logic [NC-1:0]         flush;
   logic                  uni_q;

   fts_elig_stage #(.NT(NT), .NC(NC)) u_stage (
      .clk           (clk),
      .rst_n         (rst_n),
      .unified_i     (unified_i),
      .thr_valid_i   (thr_valid_i),
      .thr_miss_i    (thr_miss_i),
      .thr_cluster_i (thr_cluster_i),
      .cand_o        (cand),
      .flush_o       (flush),
      .uni_o         (uni_q)
   );

   for (genvar c = 0; c < NC; c++) begin : g_lane
      logic [TID_W-1:0] tid;

      fts_rr_arb #(.NT(NT)) u_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .cand_i    (cand[c]),
         .flush_i   (flush[c]),
         .gnt_vld_o (gnt_vld_o[c]),
         .gnt_tid_o (tid),
         .calc_pc_o (pc_calc_o[c])
      );

      fts_pc_mux #(.NT(NT), .PC_W(PC_W)) u_mux (
         .gnt_tid_i  (tid),
         .calc_sel_i (pc_calc_o[c]),
         .thr_pc_i   (thr_pc_i),
         .pred_pc_i  (pred_pc_i[c*PC_W +: PC_W]),
         .fetch_pc_o (fetch_pc_o[c*PC_W +: PC_W])
      );

      assign gnt_tid_o[c*TID_W +: TID_W] = tid;
   end

   // R3
   unified_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uni_q |=> ((gnt_vld_o >> 1) == '0));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (gnt_vld_o == '0));

endmodule

// File: tb/sim_fetch_thread_sel.sv
module sim_fetch_thread_sel;

   localparam int CLK_PERIOD = 10;
   localparam int NT = 8;
   localparam int NC = 2;
   localparam int PW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            unified = 1'b0;
   logic [NT-1:0]   thr_valid = '0;
   logic [NT-1:0]   thr_miss = '0;
   logic [NT-1:0]   thr_cluster = '0;
   logic [NT*PW-1:0] thr_pc;
   logic [NC*PW-1:0] pred_pc;
   logic [NC-1:0]   gnt_vld;
   logic [NC*3-1:0] gnt_tid;
   logic [NC*PW-1:0] fetch_pc;
   logic [NC-1:0]   pc_calc;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      for (int t = 0; t < NT; t++) thr_pc[t*PW +: PW] = 16'h1000 + PW'(t * 16);
      for (int c = 0; c < NC; c++) pred_pc[c*PW +: PW] = 16'hA000 + PW'(c);
   end

   fetch_thread_sel #(.NT(NT), .NC(NC), .PC_W(PW)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .unified_i     (unified),
      .thr_valid_i   (thr_valid),
      .thr_miss_i    (thr_miss),
      .thr_cluster_i (thr_cluster),
      .thr_pc_i      (thr_pc),
      .pred_pc_i     (pred_pc),
      .gnt_vld_o     (gnt_vld),
      .gnt_tid_o     (gnt_tid),
      .fetch_pc_o    (fetch_pc),
      .pc_calc_o     (pc_calc)
   );

   typedef struct {
      bit          vld [NC];
      int          id  [NC];
      bit          src [NC];
      logic [PW-1:0] pc [NC];
      string       tag;
   } exp_t;

   exp_t q[$];

   // reference state: stale snapshot, lane grants, pointers
   bit [NT-1:0] m_elig = '0;
   bit [NT-1:0] m_clus = '0;
   bit          m_uni  = 0;
   bit [NC-1:0] m_flush = '0;
   bit          m_gv  [NC] = '{0, 0};
   int          m_gid [NC] = '{0, 0};
   int          m_ptr [NC] = '{NT-1, NT-1};

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit [NT-1:0] v, input bit [NT-1:0] ms,
                       input bit [NT-1:0] cl, input bit u, input string tag);
      exp_t e;
      bit [NC-1:0] nf;
      @(negedge clk);
      thr_valid = v; thr_miss = ms; thr_cluster = cl; unified = u;
      for (int c = 0; c < NC; c++) begin
         int pe, pick;
         bit fnd;
         pe = m_flush[c] ? NT-1 : m_ptr[c];
         fnd = 0; pick = 0;
         for (int i = 1; i <= NT; i++) begin
            int idx;
            bit in_lane;
            idx = (pe + i) % NT;
            in_lane = m_uni ? (c == 0) : (int'(m_clus[idx]) == c);
            if (!fnd && m_elig[idx] && in_lane) begin fnd = 1; pick = idx; end
         end
         e.vld[c] = fnd;
         e.id[c]  = pick;
         e.src[c] = fnd && (m_flush[c] || !m_gv[c] || m_gid[c] != pick);
         e.pc[c]  = e.src[c] ? 16'h1000 + PW'(pick * 16) : 16'hA000 + PW'(c);
         m_gv[c] = fnd;
         if (fnd) begin m_gid[c] = pick; m_ptr[c] = pick; end
         else if (m_flush[c]) m_ptr[c] = NT-1;
      end
      for (int c = 0; c < NC; c++) begin
         nf[c] = (u != m_uni);
         for (int t = 0; t < NT; t++)
            if (cl[t] != m_clus[t] && (int'(m_clus[t]) == c || int'(cl[t]) == c))
               nf[c] = 1;
      end
      m_flush = nf;
      m_elig  = v & ~ms;
      m_clus  = cl;
      m_uni   = u;
      e.tag   = tag;
      q.push_back(e);
   endtask

   // monitor: one expectation per rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            for (int c = 0; c < NC; c++) begin
               chk(gnt_vld[c] == e.vld[c], e.tag, $sformatf("lane%0d vld", c),
                   gnt_vld[c], e.vld[c]);
               if (e.vld[c]) begin
                  chk(int'(gnt_tid[c*3 +: 3]) == e.id[c], e.tag,
                      $sformatf("lane%0d tid", c), gnt_tid[c*3 +: 3], e.id[c]);
                  chk(pc_calc[c] == e.src[c], e.tag,
                      $sformatf("lane%0d pc source", c), pc_calc[c], e.src[c]);
                  chk(fetch_pc[c*PW +: PW] == e.pc[c], e.tag,
                      $sformatf("lane%0d pc", c), fetch_pc[c*PW +: PW], e.pc[c]);
               end
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(gnt_vld == '0, "R1", "vld in reset", gnt_vld, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(gnt_vld == '0, "R1", "vld after reset", gnt_vld, 0);

      repeat (6) step(8'hFF, 8'h00, 8'hAA, 0, "R2 R5 split rotation");
      repeat (6) step(8'hFF, 8'h12, 8'hAA, 0, "R4 miss masked");
      step(8'hFF, 8'h01, 8'hAA, 0, "R7 stale miss pulse");
      repeat (3) step(8'hFF, 8'h00, 8'hAA, 0, "R7 after pulse");
      repeat (4) step(8'h05, 8'h00, 8'hAA, 0, "R6 empty lane");
      repeat (4) step(8'h09, 8'h00, 8'hAA, 0, "R8 same thread prediction");
      repeat (10) step(8'hFF, 8'h20, 8'hAA, 1, "R3 unified");
      repeat (3) step(8'hFF, 8'h00, 8'hAA, 0, "R9 mode flush");
      repeat (5) step(8'hFF, 8'h00, 8'hAE, 0, "R9 reassign");
      repeat (3) step(8'h44, 8'h00, 8'hAE, 0, "R8 R9 single per lane");

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R7", "queue drained", q.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule